// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy multi-function I/O controller. It sits on a byte-wide I/O bus that has two addresses. The index port is at the base address and the data port is at base plus one. At power-up the configuration space is locked. It opens only after the unlock key is written twice in a row to the index port. Once open, the host writes a register number to the index port and then reads or writes that register through the data port. The selected register number stays in place, so one index write can be followed by any number of data accesses.

Registers below 0x30 are global. They hold a logical-device select, a read-only 16-bit chip identifier, and a pin multiplexing register that sets the pin function and the output drive style of each port. Registers at 0x30 and above are banked by the logical-device number. The GPIO device implements a port-enable register and, for each of two byte-wide ports, a direction, a data and an inversion register. The pin inputs pass through a two-stage synchronizer. The block drives a level and an output enable for every pin.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked. While locked, reads of either port return 0xFF and data-port writes change no register.
- R2: The space unlocks only when the index port receives 0x87 on two consecutive index writes. Any other index byte written between them restarts the sequence.
- R3: While unlocked, an index write of 0xAA locks the space again, and later port reads return 0xFF.
- R4: While unlocked, an index write stores the register number. Index-port reads return that number, and it holds through any number of data-port accesses.
- R5: Register 0x20 reads as the high byte and 0x21 as the low byte of the chip ID (default 0xA235). Writes to both are ignored.
- R6: Register 0x07 holds the logical-device number. Registers at 0x30 and above are visible only when it equals 0x09. Global registers read the same for any device number.
- R7: In device 0x09, 0xE1/0xE5 read back the output latch for bits whose direction bit (0xE0/0xE4) is 0. For bits whose direction bit is 1 they read the pin input XOR the inversion bit (0xE2/0xE6). The pin input is taken through two flops, so a change shows on the second clock edge after it.
- R8: The pin level is latch XOR inversion. Output enable is set when the port's bit in 0x30 (bit 0 first port, bit 1 second) is 1, the direction bit is 0, and either register 0x2C bit 6/7 (port 0/1) is 1 (push-pull) or the level is 0 (open drain).
- R9: The first port's output enables stay 0 unless register 0x2C bits [1:0] equal 2 (GPIO function).
- R10: Unimplemented registers, including unselected banks, read 0x00, and writes to them change nothing. Direction registers reset to 0xFF and all other registers reset to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected port (combinational) |
| gpio_in_i | input | N_PORTS*PORT_W | Pin inputs, port 0 in the low bits |
| gpio_out_o | output | N_PORTS*PORT_W | Pin drive levels |
| gpio_oe_o | output | N_PORTS*PORT_W | Pin output enables |

## Verification
A write presented in a cycle takes effect at the next rising edge. The read data and the pin outputs are combinational from the registers. The bench therefore drives each write on a falling edge and samples the result on the following falling edge, one register stage later. A pin input change needs two edges to reach a GPIO data read. The bench checks that a read after one edge still shows the old value and a read after the second edge shows the new one. In the random phase it idles two cycles after every pin change before any read.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_KEY1, ST_OPEN} lock_st_e;

  localparam logic [7:0] KEY_ENTER     = 8'h87;
  localparam logic [7:0] KEY_EXIT      = 8'hAA;
  localparam logic [7:0] REG_LDN       = 8'h07;
  localparam logic [7:0] REG_ID_HI     = 8'h20;
  localparam logic [7:0] REG_ID_LO     = 8'h21;
  localparam logic [7:0] REG_PINMUX    = 8'h2C;
  localparam logic [7:0] REG_BANK_BASE = 8'h30;
  localparam logic [7:0] REG_PORT_EN   = 8'h30;
  localparam logic [7:0] REG_PORT_BASE = 8'hE0;
  localparam logic [1:0] PINMUX_GPIO   = 2'd2;

  // k: 0 direction, 1 data, 2 inversion
  function automatic logic [7:0] port_reg(int p, int k);
    return 8'(int'(REG_PORT_BASE) + 4 * p + k);
  endfunction
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  lock_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_LOCKED;
    end else if (idx_wr_i) begin
      case (st_q)
        ST_LOCKED: st_q <= (wdata_i == KEY_ENTER) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   st_q <= (wdata_i == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   st_q <= (wdata_i == KEY_EXIT)  ? ST_LOCKED : ST_OPEN;
        default:   st_q <= ST_LOCKED;
      endcase
    end
  end

  assign open_o = (st_q == ST_OPEN);
endmodule

// File: rtl/sio_gpio_port.sv
module sio_gpio_port #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_we_i,
  input  logic              dat_we_i,
  input  logic              inv_we_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] inv_o,
  output logic [PORT_W-1:0] drive_o,
  output logic [PORT_W-1:0] rd_data_o
);
  logic [PORT_W-1:0] dir_q, dat_q, inv_q, sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '1;
      dat_q   <= '0;
      inv_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (dir_we_i) dir_q <= wdata_i;
      if (dat_we_i) dat_q <= wdata_i;
      if (inv_we_i) inv_q <= wdata_i;
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  assign dir_o     = dir_q;
  assign inv_o     = inv_q;
  assign drive_o   = dat_q ^ inv_q;
  assign rd_data_o = (dir_q & (sync2_q ^ inv_q)) | (~dir_q & dat_q);
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,        // 1..8
  parameter int unsigned N_PORTS  = 2,        // 1..2
  parameter logic [15:0] CHIP_ID  = 16'hA235,
  parameter logic [7:0]  GPIO_LDN = 8'h09
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      port_sel_i,
  input  logic                      wr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  input  logic [N_PORTS*PORT_W-1:0] gpio_in_i,
  output logic [N_PORTS*PORT_W-1:0] gpio_out_o,
  output logic [N_PORTS*PORT_W-1:0] gpio_oe_o
);
  localparam int unsigned PIN_N = N_PORTS * PORT_W;

  logic             key_open;
  logic [7:0]       idx_q, ldn_q, mf_q;
  logic [N_PORTS-1:0] en_q;
  logic             idx_wr, dat_wr, bank_hit, bank_we;
  logic [PORT_W-1:0] dir_w [N_PORTS];
  logic [PORT_W-1:0] inv_w [N_PORTS];
  logic [PORT_W-1:0] drv_w [N_PORTS];
  logic [PORT_W-1:0] rd_w  [N_PORTS];

  assign idx_wr   = wr_i & ~port_sel_i;
  assign dat_wr   = wr_i & port_sel_i & key_open;
  assign bank_hit = (idx_q >= REG_BANK_BASE) && (ldn_q == GPIO_LDN);
  assign bank_we  = dat_wr & bank_hit;

  sio_key_fsm i_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (idx_wr),
    .wdata_i  (wdata_i),
    .open_o   (key_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
      mf_q  <= '0;
      en_q  <= '0;
    end else begin
      if (idx_wr && key_open && wdata_i != KEY_EXIT) idx_q <= wdata_i;
      if (dat_wr && idx_q == REG_LDN)    ldn_q <= wdata_i;
      if (dat_wr && idx_q == REG_PINMUX) mf_q  <= wdata_i;
      if (bank_we && idx_q == REG_PORT_EN) en_q <= wdata_i[N_PORTS-1:0];
    end
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic func_ok, push_pull;
    localparam int unsigned LO = p * PORT_W;

    sio_gpio_port #(.PORT_W(PORT_W)) i_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dir_we_i  (bank_we && idx_q == port_reg(p, 0)),
      .dat_we_i  (bank_we && idx_q == port_reg(p, 1)),
      .inv_we_i  (bank_we && idx_q == port_reg(p, 2)),
      .wdata_i   (wdata_i[PORT_W-1:0]),
      .pin_i     (gpio_in_i[LO +: PORT_W]),
      .dir_o     (dir_w[p]),
      .inv_o     (inv_w[p]),
      .drive_o   (drv_w[p]),
      .rd_data_o (rd_w[p])
    );

    if (p == 0) begin : g_mux
      assign func_ok = (mf_q[1:0] == PINMUX_GPIO);
    end else begin : g_nomux
      assign func_ok = 1'b1;
    end
    assign push_pull = mf_q[6+p];

    assign gpio_out_o[LO +: PORT_W] = drv_w[p];
    assign gpio_oe_o[LO +: PORT_W]  = {PORT_W{en_q[p] & func_ok}} & ~dir_w[p]
                                      & (push_pull ? {PORT_W{1'b1}} : ~drv_w[p]);
  end

  always_comb begin
    rdata_o = 8'h00;
    if (!port_sel_i) begin
      rdata_o = key_open ? idx_q : 8'hFF;
    end else if (!key_open) begin
      rdata_o = 8'hFF;
    end else if (idx_q == REG_LDN) begin
      rdata_o = ldn_q;
    end else if (idx_q == REG_ID_HI) begin
      rdata_o = CHIP_ID[15:8];
    end else if (idx_q == REG_ID_LO) begin
      rdata_o = CHIP_ID[7:0];
    end else if (idx_q == REG_PINMUX) begin
      rdata_o = mf_q;
    end else if (bank_hit) begin
      if (idx_q == REG_PORT_EN) rdata_o = 8'(en_q);
      for (int p = 0; p < N_PORTS; p++) begin
        if (idx_q == port_reg(p, 0)) rdata_o = 8'(dir_w[p]);
        if (idx_q == port_reg(p, 1)) rdata_o = 8'(rd_w[p]);
        if (idx_q == port_reg(p, 2)) rdata_o = 8'(inv_w[p]);
      end
    end
  end

  logic unused_pin_n;
  assign unused_pin_n = (PIN_N == 0);
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned N_PORTS = 2,
  parameter logic [15:0] CHIP_ID = 16'hA235
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      port_sel_i,
  input logic                      wr_i,
  input logic [7:0]                wdata_i,
  input logic [7:0]                rdata_o,
  input logic [N_PORTS*PORT_W-1:0] gpio_out_o,
  input logic [N_PORTS*PORT_W-1:0] gpio_oe_o,
  input logic                      open_i,
  input logic [7:0]                idx_i,
  input logic [1:0]                fs_i,
  input logic [N_PORTS-1:0]        pp_i
);
  logic [N_PORTS*PORT_W-1:0] pp_mask;
  always_comb
    for (int p = 0; p < N_PORTS; p++)
      pp_mask[p*PORT_W +: PORT_W] = {PORT_W{pp_i[p]}};

  AST_LOCKED_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |-> rdata_o == 8'hFF); // R1

  AST_UNLOCK_AFTER_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_i) |-> $past(wr_i && !port_sel_i && wdata_i == 8'h87)); // R2

  AST_EXIT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && wr_i && !port_sel_i && wdata_i == 8'hAA) |=> !open_i); // R3

  AST_INDEX_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !port_sel_i) |=> $stable(idx_i)); // R4

  AST_CHIP_ID_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && port_sel_i && idx_i == 8'h20) |-> rdata_o == CHIP_ID[15:8]); // R5

  AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_oe_o & gpio_out_o & ~pp_mask) == '0); // R8

  AST_PORT0_MUX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_i != 2'd2 |-> gpio_oe_o[PORT_W-1:0] == '0); // R9
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .PORT_W(PORT_W), .N_PORTS(N_PORTS), .CHIP_ID(CHIP_ID)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .port_sel_i (port_sel_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .gpio_out_o (gpio_out_o),
  .gpio_oe_o  (gpio_oe_o),
  .open_i     (key_open),
  .idx_i      (idx_q),
  .fs_i       (mf_q[1:0]),
  .pp_i       (mf_q[6 +: N_PORTS])
);

// File: tb/test_sio_cfg_port.sv
`timescale 1ns/1ps
module test_sio_cfg_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        port_sel = 0;
  logic        wr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [15:0] pins = 0;
  logic [15:0] gout, goe;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk_i(clk), .rst_ni(rst_n), .port_sel_i(port_sel), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_in_i(pins),
    .gpio_out_o(gout), .gpio_oe_o(goe)
  );

  // reference model
  int        m_st = 0;  // 0 locked, 1 one key seen, 2 open
  logic [7:0] m_idx = 0, m_ldn = 0, m_mf = 0;
  logic [1:0] m_en = 0;
  logic [7:0] m_dir [2] = '{8'hFF, 8'hFF};
  logic [7:0] m_dat [2] = '{8'h00, 8'h00};
  logic [7:0] m_inv [2] = '{8'h00, 8'h00};

  function automatic logic bank();
    return m_idx >= 8'h30 && m_ldn == 8'h09;
  endfunction

  function automatic logic [7:0] exp_data();
    if (m_st != 2) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'hA2;
      8'h21: return 8'h35;
      8'h2C: return m_mf;
      default: ;
    endcase
    if (!bank()) return 8'h00;
    for (int p = 0; p < 2; p++) begin
      if (m_idx == 8'(8'hE0 + 4*p)) return m_dir[p];
      if (m_idx == 8'(8'hE1 + 4*p))
        return (m_dir[p] & (pins[p*8 +: 8] ^ m_inv[p])) | (~m_dir[p] & m_dat[p]);
      if (m_idx == 8'(8'hE2 + 4*p)) return m_inv[p];
    end
    if (m_idx == 8'h30) return {6'b0, m_en};
    return 8'h00;
  endfunction

  function automatic logic [15:0] exp_out();
    return {m_dat[1] ^ m_inv[1], m_dat[0] ^ m_inv[0]};
  endfunction

  function automatic logic [15:0] exp_oe();
    logic [15:0] r;
    for (int p = 0; p < 2; p++) begin
      logic [7:0] lvl = m_dat[p] ^ m_inv[p];
      logic ok = m_en[p] && (p == 1 || m_mf[1:0] == 2'd2);
      r[p*8 +: 8] = {8{ok}} & ~m_dir[p] & (m_mf[6+p] ? 8'hFF : ~lvl);
    end
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic sel, logic [7:0] d);
    @(negedge clk);
    port_sel = sel; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
    if (!sel) begin
      if (m_st == 2) begin
        if (d == 8'hAA) m_st = 0; else m_idx = d;
      end else if (d == 8'h87) m_st = m_st + 1;
      else m_st = 0;
    end else if (m_st == 2) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx == 8'h2C) m_mf = d;
      else if (bank()) begin
        if (m_idx == 8'h30) m_en = d[1:0];
        for (int p = 0; p < 2; p++) begin
          if (m_idx == 8'(8'hE0 + 4*p)) m_dir[p] = d;
          if (m_idx == 8'(8'hE1 + 4*p)) m_dat[p] = d;
          if (m_idx == 8'(8'hE2 + 4*p)) m_inv[p] = d;
        end
      end
    end
  endtask

  task automatic rd_data(string req);
    @(negedge clk);
    port_sel = 1; #0.5;
    chk(req, rdata, exp_data());
  endtask

  task automatic rd_index(string req);
    @(negedge clk);
    port_sel = 0; #0.5;
    chk(req, rdata, (m_st == 2) ? m_idx : 8'hFF);
  endtask

  task automatic chk_pins(string req);
    #0.5;
    chk(req, gout, exp_out());
    chk(req, goe, exp_oe());
  endtask

  task automatic unlock();
    bus_wr(0, 8'h87); bus_wr(0, 8'h87);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd_data("R1"); rd_index("R1"); chk_pins("R10");
    bus_wr(1, 8'h55);              // ignored while locked
    // R2 broken sequence stays locked
    bus_wr(0, 8'h87); bus_wr(0, 8'h12); bus_wr(0, 8'h87);
    rd_data("R2");
    bus_wr(0, 8'h87);
    rd_index("R2");                // open now, index still 00
    bus_wr(0, 8'h07); rd_data("R1");   // locked write did not land
    // R5 chip ID read-only
    bus_wr(0, 8'h20); rd_data("R5"); bus_wr(1, 8'h00); rd_data("R5");
    bus_wr(0, 8'h21); rd_data("R5");
    // R10 unimplemented
    bus_wr(0, 8'h55); bus_wr(1, 8'hC3); rd_data("R10");
    // R6 bank select
    bus_wr(0, 8'hE0); bus_wr(1, 8'h00); rd_data("R6");  // ldn=0: ignored
    bus_wr(0, 8'h07); bus_wr(1, 8'h09);
    bus_wr(0, 8'hE0); rd_data("R10");                   // dir reset FF
    // R4 one index, several data accesses
    bus_wr(1, 8'h0F); rd_data("R4"); rd_index("R4"); rd_data("R4");
    // R8 port 0 drive
    bus_wr(0, 8'hE1); bus_wr(1, 8'hA5);
    bus_wr(0, 8'h30); bus_wr(1, 8'h03); chk_pins("R9");
    bus_wr(0, 8'h2C); bus_wr(1, 8'h02); chk_pins("R8");  // open drain
    bus_wr(1, 8'h42); chk_pins("R8");                    // push-pull
    bus_wr(1, 8'h01); chk_pins("R9");                    // IR function
    bus_wr(1, 8'hC2);
    bus_wr(0, 8'h07); bus_wr(1, 8'h09);
    bus_wr(0, 8'hE2); bus_wr(1, 8'hFF); chk_pins("R8");
    // R7 input latency
    bus_wr(0, 8'hE1);
    @(negedge clk); pins = 16'h5A5A;
    @(negedge clk); port_sel = 1; #0.5;
    chk("R7", rdata, (8'h0F & (8'h00 ^ 8'hFF)) | (8'hF0 & 8'hA5));
    @(negedge clk); #0.5;
    chk("R7", rdata, (8'h0F & (8'h5A ^ 8'hFF)) | (8'hF0 & 8'hA5));
    // R6 globals independent of device
    bus_wr(0, 8'h07); bus_wr(1, 8'h03);
    bus_wr(0, 8'h2C); rd_data("R6");
    bus_wr(0, 8'hE1); rd_data("R6");
    bus_wr(0, 8'h07); bus_wr(1, 8'h09);
    // R3 exit
    bus_wr(0, 8'hAA); rd_data("R3"); rd_index("R3");
    unlock(); rd_index("R4");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom % 11;
      case (op)
        0, 1, 2: begin
          logic [7:0] v;
          case ($urandom % 12)
            0, 11: v = 8'h87;
            1: v = 8'hAA;
            2: v = 8'h07;
            3: v = 8'h20;
            4: v = 8'h21;
            5: v = 8'h2C;
            6: v = 8'h30;
            7: v = 8'(8'hE0 + $urandom % 8);
            8: v = 8'($urandom);
            9: v = 8'hE1;
            default: v = 8'hE5;
          endcase
          bus_wr(0, v); chk_pins("R8");
        end
        3, 4: begin
          logic [7:0] v = 8'($urandom);
          if (m_idx == 8'h07 && ($urandom % 4) != 0) v = 8'h09;
          bus_wr(1, v); chk_pins("R8");
        end
        5, 6: rd_data(m_idx >= 8'hE0 ? "R7" : "R6");
        7: rd_index("R4");
        8: begin
          @(negedge clk); pins = 16'($urandom);
          idle(2); chk_pins("R9");
        end
        default: if (m_st != 2) unlock();
      endcase
    end

    finish_run();
  end
endmodule